// File: doc/BRIEF.md
# Radix-4 Recoded Signed Multiplier

This block multiplies two 8-bit signed two's-complement operands and returns their 16-bit signed product. The second operand, called the multiplier, is recoded into four signed radix-4 digits. Each digit picks one multiple of the first operand, called the multiplicand. The four multiples are 0, ±X and ±2X. Because of this, the arithmetic sums four partial products where a plain array multiplier would sum eight.

Each partial product is extended to the full product width and shifted into place. A negative multiple is formed by inverting a magnitude. The +1 that completes its two's complement is carried as a separate correction row. The partial products and the correction row go through a carry-save tree of full adders, which reduces them to two rows. A logarithmic-depth prefix adder then sums those two rows. The product can be registered at the output or taken straight from the logic, as a parameter selects.

Top module: `r4_mult`

## Requirements
- R1: For every pair of signed 8-bit operands, `product` equals the signed product of `a` and `b`, reduced to 16 bits. This includes -128 times -128, which gives +16384.
- R2: With the output register enabled (the default), `product` shows the result for the operands sampled at the previous rising clock edge. While `rst_n` is low, `product` is 0.
- R3: Radix-4 digit i is decoded from `b` bits 2i+1, 2i and 2i-1, with bit -1 taken as 0. Each digit has a value in {-2,-1,0,+1,+2} and a weight of 4^i. The product is correct for multipliers that exercise every digit position and every digit value, including -128, which is recoded with a top digit of -2.
- R4: Negative multiples are exact. For b = -1 the product is -a, and for b = -2 it is -2a, for every a, including a = -128.
- R5: Doubled multiples are exact. For b = +2 the product is 2a, including 2·127 = 254 and 2·(-128) = -256.
- R6: When either operand is 0, the product is 0, whatever the other operand and whatever the previous result.
- R7: When both operands are non-zero, bit 15 of the product equals the XOR of the operands' sign bits.
- R8: While both operands hold steady, `product` does not change.
- R9: The sign extension of partial products is exact at the range limits: -128·127 = -16256, 127·127 = 16129 and -1·-1 = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset; clears the product register |
| a | input | 8 | Multiplicand, signed two's complement |
| b | input | 8 | Multiplier, signed two's complement; this operand is recoded |
| product | output | 16 | Signed product |

## Verification
A faulty digit decode adds a wrong multiple of a·4^i to the result, so the product is off by that amount one clock after the operands are applied. Only multipliers whose bit triple at that position selects the faulty code show the error, which is why the bench drives every operand pair. A missing correction bit or a wrong sign extension makes the result off by a small power of two, or flips the upper bits, and only for negative multiples. The directed negation, doubling and range-limit cases expose these errors on the first sampled cycle.

// File: rtl/bmul_pkg.sv
package bmul_pkg;
    // One radix-4 digit: magnitude one-hot (one/two) plus sign.
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } digit_t;
endpackage

// File: rtl/bmul_recode.sv
module bmul_recode #(
    parameter int W = 8
) (
    input  logic [W-1:0]                  mplier,
    output bmul_pkg::digit_t [W/2-1:0]    dig
);
    for (genvar i = 0; i < W/2; i++) begin : g_dig
        logic hi, mid, lo;
        assign hi  = mplier[2*i+1];
        assign mid = mplier[2*i];
        if (i == 0) begin : g_first
            assign lo = 1'b0;
        end else begin : g_rest
            assign lo = mplier[2*i-1];
        end
        assign dig[i].neg = hi & ~(mid & lo);
        assign dig[i].one = mid ^ lo;
        assign dig[i].two = (hi & ~mid & ~lo) | (~hi & mid & lo);
    end
endmodule

// File: rtl/bmul_ppgen.sv
module bmul_ppgen #(
    parameter int W  = 8,
    parameter int PW = 2 * W
) (
    input  logic [W-1:0]                  mcand,
    input  bmul_pkg::digit_t [W/2-1:0]    dig,
    output logic [W/2-1:0][PW-1:0]        rows,
    output logic [PW-1:0]                 corr
);
    for (genvar i = 0; i < W/2; i++) begin : g_pp
        logic [W:0] mag;
        logic [W:0] sel;
        always_comb begin
            if (dig[i].one)      mag = {mcand[W-1], mcand};
            else if (dig[i].two) mag = {mcand, 1'b0};
            else                 mag = '0;
            sel = mag ^ {(W+1){dig[i].neg}};
        end
        // full-width sign extension, then weight by 4^i
        assign rows[i] = {{(PW-W-1){sel[W]}}, sel} << (2*i);
    end

    // +1 completions for inverted (negative) multiples
    always_comb begin
        corr = '0;
        for (int i = 0; i < W/2; i++) corr[2*i] = dig[i].neg;
    end
endmodule

// File: rtl/bmul_csa.sv
module bmul_csa #(
    parameter int PW = 16,
    parameter int NR = 5
) (
    input  logic [NR-1:0][PW-1:0] rows_in,
    output logic [PW-1:0]         sum_row,
    output logic [PW-1:0]         carry_row
);
    logic [PW-1:0] cur [NR];
    logic [PW-1:0] nxt [NR];
    logic [PW-1:0] x, y, z;
    int n, m, q;

    always_comb begin
        for (int k = 0; k < NR; k++) cur[k] = rows_in[k];
        for (int k = 0; k < NR; k++) nxt[k] = '0;
        x = '0; y = '0; z = '0;
        n = NR; m = 0; q = 0;
        for (int lvl = 0; lvl < NR; lvl++) begin
            if (n > 2) begin
                for (int k = 0; k < NR; k++) nxt[k] = '0;
                m = 0;
                q = n / 3;
                for (int g = 0; g < NR; g++) begin
                    if (g < q) begin
                        x = cur[3*g];
                        y = cur[3*g+1];
                        z = cur[3*g+2];
                        nxt[m]   = x ^ y ^ z;
                        nxt[m+1] = ((x & y) | (x & z) | (y & z)) << 1;
                        m = m + 2;
                    end
                end
                for (int j = 0; j < NR; j++) begin
                    if (3*q + j < n) begin
                        nxt[m] = cur[3*q + j];
                        m = m + 1;
                    end
                end
                for (int k = 0; k < NR; k++) cur[k] = nxt[k];
                n = m;
            end
        end
        sum_row   = cur[0];
        carry_row = (n > 1) ? cur[1] : '0;
    end
endmodule

// File: rtl/bmul_ksa.sv
module bmul_ksa #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] x,
    input  logic [PW-1:0] y,
    output logic [PW-1:0] s
);
    localparam int LV = $clog2(PW);

    logic [LV:0][PW-1:0]   gg;
    logic [LV-1:0][PW-1:0] pp;

    assign gg[0] = x & y;
    assign pp[0] = x ^ y;

    for (genvar l = 0; l < LV; l++) begin : g_lvl
        for (genvar i = 0; i < PW; i++) begin : g_bit
            if (i >= (1 << l)) begin : g_op
                assign gg[l+1][i] = gg[l][i] | (pp[l][i] & gg[l][i-(1<<l)]);
                if (l + 1 < LV) begin : g_p
                    assign pp[l+1][i] = pp[l][i] & pp[l][i-(1<<l)];
                end
            end else begin : g_pass
                assign gg[l+1][i] = gg[l][i];
                if (l + 1 < LV) begin : g_p
                    assign pp[l+1][i] = pp[l][i];
                end
            end
        end
    end

    assign s = pp[0] ^ {gg[LV][PW-2:0], 1'b0};

    logic unused_cout;
    assign unused_cout = gg[LV][PW-1];
endmodule

// File: rtl/r4_mult.sv
module r4_mult #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] product
);
    localparam int ND = W / 2;
    localparam int PW = 2 * W;
    localparam int NR = ND + 1;

    typedef struct packed {
        logic [PW-1:0] prod;
    } state_t;

    bmul_pkg::digit_t [ND-1:0] dig;
    logic [ND-1:0][PW-1:0]     pp_rows;
    logic [PW-1:0]             corr;
    logic [NR-1:0][PW-1:0]     all_rows;
    logic [PW-1:0]             sum_row, carry_row, sum_w;
    state_t                    state_d, state_q;

    bmul_recode #(.W(W)) u_recode (.mplier(b), .dig(dig));

    bmul_ppgen #(.W(W), .PW(PW)) u_ppgen (
        .mcand(a), .dig(dig), .rows(pp_rows), .corr(corr)
    );

    always_comb begin
        for (int i = 0; i < ND; i++) all_rows[i] = pp_rows[i];
        all_rows[ND] = corr;
    end

    bmul_csa #(.PW(PW), .NR(NR)) u_csa (
        .rows_in(all_rows), .sum_row(sum_row), .carry_row(carry_row)
    );

    bmul_ksa #(.PW(PW)) u_ksa (.x(sum_row), .y(carry_row), .s(sum_w));

    always_comb begin
        state_d      = '0;
        state_d.prod = sum_w;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_q <= '0;
            else        state_q <= state_d;
        end
        assign product = state_q.prod;
    end else begin : g_comb
        assign state_q = state_d;
        assign product = state_q.prod;
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
    end
endmodule

// File: rtl/r4_mult_chk.sv
module r4_mult_chk #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [W-1:0]   a,
    input logic [W-1:0]   b,
    input logic [2*W-1:0] product
);
    logic signed [2*W-1:0] ref_now;
    assign ref_now = $signed(a) * $signed(b);

    if (REG_OUT) begin : g_reg
        logic armed_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) armed_q <= 1'b0;
            else        armed_q <= 1'b1;
        end

        p_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> product == $past(ref_now));
        p_reset_r2: assert property (@(posedge clk)
            !rst_n |-> product == '0);
        p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (a == '0 || b == '0) |=> product == '0);
        p_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (a != '0 && b != '0) |=> product[2*W-1] == $past(a[W-1] ^ b[W-1]));
        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && $stable(a) && $stable(b)) |=> $stable(product));
    end else begin : g_comb
        p_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |-> product == ref_now);
        p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (a == '0 || b == '0) |-> product == '0);
        p_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (a != '0 && b != '0) |-> product[2*W-1] == (a[W-1] ^ b[W-1]));
        p_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (b == '1) |-> product == -{{W{a[W-1]}}, a});
    end
endmodule

bind r4_mult r4_mult_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .product(product)
);

// File: tb/tb_r4_mult.sv
`timescale 1ns/1ps
module tb_r4_mult;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  a, b;
    logic [15:0] product;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    r4_mult dut (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .product(product));

    function automatic logic [15:0] expect_of(input logic [7:0] x, input logic [7:0] y);
        int sx, sy;
        sx = $signed(x);
        sy = $signed(y);
        return 16'(sx * sy);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (a=%h b=%h)", req, act, exp, a, b);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic apply(input string req, input logic [7:0] x, input logic [7:0] y);
        @(negedge clk);
        a = x; b = y;
        @(negedge clk);
        chk(req, product, expect_of(x, y));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; a = 8'd5; b = 8'd7;
        repeat (3) @(negedge clk);
        chk("R2 reset", product, 16'h0000);
        rst_n = 1'b1;
        a = 8'd3; b = 8'hFC;
        @(negedge clk);
        chk("R2 latency", product, 16'hFFF4);
    endtask

    task automatic t_digits();
        for (int k = 0; k < 8; k++) apply("R3 digit pos", 8'd7, 8'(1 << k));
        apply("R3 pattern", 8'd93, 8'h55);
        apply("R3 pattern", 8'd93, 8'hAA);
        apply("R3 pattern", 8'hB5, 8'h33);
        apply("R3 pattern", 8'hB5, 8'hCC);
        apply("R3 pattern", 8'd41, 8'h7F);
        apply("R3 top -2", 8'd41, 8'h80);
    endtask

    task automatic t_negmul();
        apply("R4 b=-1", 8'd100, 8'hFF);
        apply("R4 b=-1", 8'h80, 8'hFF);
        apply("R4 b=-2", 8'd77, 8'hFE);
        apply("R4 b=-2", 8'h80, 8'hFE);
    endtask

    task automatic t_double();
        apply("R5 b=2", 8'd127, 8'd2);
        apply("R5 b=2", 8'h80, 8'd2);
        apply("R5 b=2", 8'hC3, 8'd2);
    endtask

    task automatic t_zero();
        apply("R6 prime", 8'd99, 8'd99);
        apply("R6 a=0", 8'd0, 8'h80);
        apply("R6 prime", 8'h81, 8'h81);
        apply("R6 b=0", 8'h80, 8'd0);
    endtask

    task automatic t_sign();
        @(negedge clk);
        a = 8'hF3; b = 8'd9;
        @(negedge clk);
        checks++;
        if (product[15] !== 1'b1) begin
            failures++;
            $display("FAIL R7 sign actual=%b expected=1", product[15]);
        end
        a = 8'hF3; b = 8'hF7;
        @(negedge clk);
        checks++;
        if (product[15] !== 1'b0) begin
            failures++;
            $display("FAIL R7 sign actual=%b expected=0", product[15]);
        end
    endtask

    task automatic t_hold();
        apply("R8 load", 8'hB3, 8'd55);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R8 hold", product, expect_of(8'hB3, 8'd55));
        end
    endtask

    task automatic t_corners();
        apply("R1 -128*-128", 8'h80, 8'h80);
        apply("R9 -128*127", 8'h80, 8'h7F);
        apply("R9 127*127", 8'h7F, 8'h7F);
        apply("R9 -1*-1", 8'hFF, 8'hFF);
    endtask

    task automatic t_exhaustive();
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                apply("R1 all pairs", 8'(i), 8'(j));
            end
        end
    endtask

    initial begin
        a = '0; b = '0; rst_n = 1'b0;
        t_reset();
        t_digits();
        t_negmul();
        t_double();
        t_zero();
        t_sign();
        t_hold();
        t_corners();
        t_exhaustive();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule